// File: doc/BRIEF.md
# Display Command List Pointer Controller

This block is the register front end a display command processor uses to find its command list in memory. Software writes a start pointer, then an end pointer. The block keeps those two pointers, a current pointer, a status word, three busy-cycle counters and a free-running clock counter, and drives all of them onto read ports.

A start write is buffered through a start-valid flag. The first start write after the flag was cleared captures the address and raises the flag. Later start writes are dropped until an end write consumes the flag. An end write always records the end address. If the flag is up, the same write moves the buffered start into the current pointer and lowers the flag.

A one-cycle list-ready pulse follows every end write. It tells the downstream fetcher that a new list boundary exists. Status writes use paired clear/set bits for three mode flags, with clear taking priority, and single clear bits that zero the counters.

Top module: `cmdlist_ptr_ctrl`

## Requirements
- R1: While reset is asserted, all pointers, the status word, all counters and list_ready_o read zero.
- R2: Start and end pointers store write data bits [23:3] with bits [2:0] forced to zero. Data bits above 23 are dropped.
- R3: A start write (wr_sel_i=0) while start-valid (status bit 10) is clear loads the start pointer and sets start-valid.
- R4: A start write while start-valid is set leaves the start pointer unchanged, and start-valid stays set.
- R5: An end write (wr_sel_i=1) always loads the end pointer. If start-valid is set, the same write copies start into current and clears start-valid. Otherwise current is unchanged.
- R6: list_ready_o is high for exactly the one cycle after each end write and low otherwise.
- R7: A status write (wr_sel_i=2) uses data bits 0/1, 2/3 and 4/5 to clear/set the xbus-DMA (status bit 0), freeze (bit 1) and flush (bit 2) flags. When both bits of a pair are set, the clear wins.
- R8: Each busy counter (tmem, pipe, cmd) increments on every cycle its busy input is high. The matching status bit (4, 5, 6) becomes set and stays set.
- R9: Status write data bits 6, 7 and 8 zero the tmem, pipe and cmd counter respectively, and clear the matching busy status bit. The clear overrides an increment in the same cycle.
- R10: The clock counter increments every cycle while freeze is clear and holds while freeze is set. Status write data bit 9 zeroes it and touches nothing else.
- R11: Status bits 3, 7, 8 and 9 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 start, 1 end, 2 status |
| wr_data_i | input | 32 | Write data |
| tmem_busy_i | input | 1 | Texture memory busy indication |
| pipe_busy_i | input | 1 | Pipeline busy indication |
| cmd_busy_i | input | 1 | Command unit busy indication |
| start_ptr_o | output | 24 | Buffered start pointer |
| end_ptr_o | output | 24 | End pointer |
| cur_ptr_o | output | 24 | Current pointer |
| status_o | output | 11 | Status word |
| tmem_cnt_o | output | 24 | Texture memory busy counter |
| pipe_cnt_o | output | 24 | Pipeline busy counter |
| cmd_cnt_o | output | 24 | Command busy counter |
| clk_cnt_o | output | 24 | Clock counter |
| list_ready_o | output | 1 | One-cycle pulse after an end write |

## Verification
The pointer path is driven with one sequence of start and end writes:
- Fresh and repeated starts, which separate a loaded start from a dropped one.
- End writes with start-valid set and with it clear, which show whether current is copied or left alone.
- Addresses with low and high garbage bits, which expose masking mistakes.

Status writes cover set-only, clear-only and both-bits patterns, so that a swapped clear/set priority is caught. Busy inputs are held for differing lengths, and a clear is issued in the same cycle as an active busy input, which shows whether clear overrides increment. The clock counter is compared across freeze and unfreeze, and around a clock-only clear that must leave the busy state untouched.

// File: rtl/cmdlist_pkg.sv
package cmdlist_pkg;
  typedef enum logic [1:0] {
    SEL_START  = 2'd0,
    SEL_END    = 2'd1,
    SEL_STATUS = 2'd2
  } wr_sel_e;

  localparam int ST_XBUS    = 0;
  localparam int ST_FREEZE  = 1;
  localparam int ST_FLUSH   = 2;
  localparam int ST_TMEM    = 4;
  localparam int ST_PIPE    = 5;
  localparam int ST_CMD     = 6;
  localparam int ST_SVALID  = 10;
  localparam int ST_W       = 11;

  localparam int CMD_W      = 10;
  localparam int NUM_BUSY   = 3;
  localparam int CLR_BUSY0  = 6;
  localparam int CLR_CLOCK  = 9;
endpackage

// File: rtl/cmdlist_counter.sv
module cmdlist_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = inc_i | clr_i;
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/cmdlist_ptr_regs.sv
module cmdlist_ptr_regs #(
  parameter int ADDR_W = 24,
  parameter int ALIGN  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_wr_i,
  input  logic              end_wr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] start_o,
  output logic [ADDR_W-1:0] end_o,
  output logic [ADDR_W-1:0] cur_o,
  output logic              start_valid_o,
  output logic              ready_o
);
  logic [ADDR_W-1:0] addr_m;
  logic [ADDR_W-1:0] start_q, end_q, cur_q;
  logic              sv_q, sv_d, rdy_q;
  logic              start_en, cur_en;

  always_comb begin
    addr_m   = {wdata_i[ADDR_W-1:ALIGN], {ALIGN{1'b0}}};
    start_en = start_wr_i & ~sv_q;
    cur_en   = end_wr_i & sv_q;
    sv_d     = sv_q;
    if (start_wr_i)    sv_d = 1'b1;
    else if (end_wr_i) sv_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      end_q   <= '0;
      cur_q   <= '0;
      sv_q    <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      if (start_en) start_q <= addr_m;
      if (end_wr_i) end_q   <= addr_m;
      if (cur_en)   cur_q   <= start_q;
      sv_q  <= sv_d;
      rdy_q <= end_wr_i;
    end
  end

  assign start_o       = start_q;
  assign end_o         = end_q;
  assign cur_o         = cur_q;
  assign start_valid_o = sv_q;
  assign ready_o       = rdy_q;

  assert_start_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_wr_i && sv_q) |=> ($stable(start_q) && sv_q));
  assert_end_copy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_wr_i && sv_q) |=> ((cur_q == $past(start_q)) && !sv_q));
  assert_start_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_wr_i && !sv_q) |=> sv_q);
endmodule

// File: rtl/cmdlist_status_ctrl.sv
module cmdlist_status_ctrl
  import cmdlist_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [CMD_W-1:0]    cmd_i,
  input  logic [NUM_BUSY-1:0] busy_i,
  output logic                xbus_o,
  output logic                freeze_o,
  output logic                flush_o,
  output logic [NUM_BUSY-1:0] busy_flag_o,
  output logic [NUM_BUSY-1:0] busy_clr_o,
  output logic                clk_clr_o
);
  logic [2:0]          flag_q, flag_d;
  logic [NUM_BUSY-1:0] bflag_q, bflag_d;

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      flag_d[i] = flag_q[i];
      if (wr_i && cmd_i[2*i])        flag_d[i] = 1'b0;
      else if (wr_i && cmd_i[2*i+1]) flag_d[i] = 1'b1;
    end
    for (int b = 0; b < NUM_BUSY; b++) begin
      busy_clr_o[b] = wr_i & cmd_i[CLR_BUSY0+b];
      if (busy_clr_o[b])  bflag_d[b] = 1'b0;
      else if (busy_i[b]) bflag_d[b] = 1'b1;
      else                bflag_d[b] = bflag_q[b];
    end
    clk_clr_o = wr_i & cmd_i[CLR_CLOCK];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= '0;
      bflag_q <= '0;
    end else begin
      flag_q  <= flag_d;
      bflag_q <= bflag_d;
    end
  end

  assign xbus_o      = flag_q[0];
  assign freeze_o    = flag_q[1];
  assign flush_o     = flag_q[2];
  assign busy_flag_o = bflag_q;

  assert_clear_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && cmd_i[2] && cmd_i[3]) |=> !freeze_o);
  assert_busy_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i[0] && !busy_clr_o[0]) |=> busy_flag_o[0]);
endmodule

// File: rtl/cmdlist_ptr_ctrl.sv
module cmdlist_ptr_ctrl
  import cmdlist_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24,
  parameter int ALIGN  = 3,
  parameter int CNT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tmem_busy_i,
  input  logic              pipe_busy_i,
  input  logic              cmd_busy_i,
  output logic [ADDR_W-1:0] start_ptr_o,
  output logic [ADDR_W-1:0] end_ptr_o,
  output logic [ADDR_W-1:0] cur_ptr_o,
  output logic [ST_W-1:0]   status_o,
  output logic [CNT_W-1:0]  tmem_cnt_o,
  output logic [CNT_W-1:0]  pipe_cnt_o,
  output logic [CNT_W-1:0]  cmd_cnt_o,
  output logic [CNT_W-1:0]  clk_cnt_o,
  output logic              list_ready_o
);
  logic                start_wr, end_wr, stat_wr;
  logic                xbus, freeze, flush, svalid, clk_clr;
  logic [NUM_BUSY-1:0] busy_in, busy_flag, busy_clr;
  logic [CNT_W-1:0]    busy_cnt [NUM_BUSY];
  logic                unused_hi;

  assign unused_hi = ^wr_data_i[DATA_W-1:ADDR_W];
  assign start_wr  = wr_en_i & (wr_sel_i == SEL_START);
  assign end_wr    = wr_en_i & (wr_sel_i == SEL_END);
  assign stat_wr   = wr_en_i & (wr_sel_i == SEL_STATUS);
  assign busy_in   = {cmd_busy_i, pipe_busy_i, tmem_busy_i};

  cmdlist_ptr_regs #(.ADDR_W(ADDR_W), .ALIGN(ALIGN)) u_ptr (
    .clk_i, .rst_ni,
    .start_wr_i(start_wr), .end_wr_i(end_wr), .wdata_i(wr_data_i[ADDR_W-1:0]),
    .start_o(start_ptr_o), .end_o(end_ptr_o), .cur_o(cur_ptr_o),
    .start_valid_o(svalid), .ready_o(list_ready_o)
  );

  cmdlist_status_ctrl u_stat (
    .clk_i, .rst_ni, .wr_i(stat_wr), .cmd_i(wr_data_i[CMD_W-1:0]),
    .busy_i(busy_in), .xbus_o(xbus), .freeze_o(freeze), .flush_o(flush),
    .busy_flag_o(busy_flag), .busy_clr_o(busy_clr), .clk_clr_o(clk_clr)
  );

  for (genvar g = 0; g < NUM_BUSY; g++) begin : g_busy_cnt
    cmdlist_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i, .rst_ni, .inc_i(busy_in[g]), .clr_i(busy_clr[g]), .cnt_o(busy_cnt[g])
    );
  end

  cmdlist_counter #(.CNT_W(CNT_W)) u_clk_cnt (
    .clk_i, .rst_ni, .inc_i(~freeze), .clr_i(clk_clr), .cnt_o(clk_cnt_o)
  );

  assign tmem_cnt_o = busy_cnt[0];
  assign pipe_cnt_o = busy_cnt[1];
  assign cmd_cnt_o  = busy_cnt[2];

  always_comb begin
    status_o             = '0;
    status_o[ST_XBUS]    = xbus;
    status_o[ST_FREEZE]  = freeze;
    status_o[ST_FLUSH]   = flush;
    status_o[ST_TMEM]    = busy_flag[0];
    status_o[ST_PIPE]    = busy_flag[1];
    status_o[ST_CMD]     = busy_flag[2];
    status_o[ST_SVALID]  = svalid;
  end

  assert_ready_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (list_ready_o && !end_wr) |=> !list_ready_o);
  assert_reserved_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3] == 1'b0) && (status_o[9:7] == 3'b000));
endmodule

// File: tb/cmdlist_ptr_ctrl_tb.sv
module cmdlist_ptr_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        wr_en_i;
  logic [1:0]  wr_sel_i;
  logic [31:0] wr_data_i;
  logic        tmem_busy_i, pipe_busy_i, cmd_busy_i;
  logic [23:0] start_ptr_o, end_ptr_o, cur_ptr_o;
  logic [10:0] status_o;
  logic [23:0] tmem_cnt_o, pipe_cnt_o, cmd_cnt_o, clk_cnt_o;
  logic        list_ready_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  cmdlist_ptr_ctrl dut_i (.*);

  // {sel, data, exp_start, exp_end, exp_cur, exp_svalid}
  typedef struct packed {
    logic [1:0]  sel;
    logic [31:0] data;
    logic [23:0] e_start;
    logic [23:0] e_end;
    logic [23:0] e_cur;
    logic        e_sv;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 32'hAB12345F, 24'h123458, 24'h000000, 24'h000000, 1'b1},
    '{2'd0, 32'h00FFFFFF, 24'h123458, 24'h000000, 24'h000000, 1'b1},
    '{2'd1, 32'hFF00ABCD, 24'h123458, 24'h00ABC8, 24'h123458, 1'b0},
    '{2'd1, 32'h00000017, 24'h123458, 24'h000010, 24'h123458, 1'b0},
    '{2'd0, 32'h00FFFFFF, 24'hFFFFF8, 24'h000010, 24'h123458, 1'b1},
    '{2'd1, 32'h00000800, 24'hFFFFF8, 24'h000800, 24'hFFFFF8, 1'b0}
  };

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] c0;
    rst_ni = 1'b0; wr_en_i = 1'b0; wr_sel_i = '0; wr_data_i = '0;
    tmem_busy_i = 1'b0; pipe_busy_i = 1'b0; cmd_busy_i = 1'b0;
    repeat (3) step();
    chk("R1 start", start_ptr_o, 0);
    chk("R1 end", end_ptr_o, 0);
    chk("R1 cur", cur_ptr_o, 0);
    chk("R1 status", status_o, 0);
    chk("R1 clk_cnt", clk_cnt_o, 0);
    chk("R1 tmem_cnt", tmem_cnt_o, 0);
    chk("R1 ready", list_ready_o, 0);
    rst_ni = 1'b1;
    step();

    // R2 R3 R4 R5 R6: pointer sequence
    for (int i = 0; i < 6; i++) begin
      wr(VECS[i].sel, VECS[i].data);
      chk("R2/R3/R4 start", start_ptr_o, VECS[i].e_start);
      chk("R2/R5 end", end_ptr_o, VECS[i].e_end);
      chk("R5 cur", cur_ptr_o, VECS[i].e_cur);
      chk("R3/R5 svalid", status_o[10], VECS[i].e_sv);
      chk("R6 ready", list_ready_o, (VECS[i].sel == 2'd1));
    end
    step();
    chk("R6 pulse ends", list_ready_o, 0);

    // R7 flags
    wr(2'd2, 32'h2A);
    chk("R7 set all", status_o[2:0], 3'b111);
    wr(2'd2, 32'h0C);
    chk("R7 freeze clear wins", status_o[2:0], 3'b101);
    wr(2'd2, 32'h11);
    chk("R7 clear xbus flush", status_o[2:0], 3'b000);
    wr(2'd2, 32'h2A);
    wr(2'd2, 32'h3F);
    chk("R7 all pairs clear wins", status_o[2:0], 3'b000);

    // R10 clock counter vs freeze
    c0 = clk_cnt_o;
    repeat (5) step();
    chk("R10 running", clk_cnt_o, c0 + 24'd5);
    wr(2'd2, 32'h08);
    c0 = clk_cnt_o;
    repeat (5) step();
    chk("R10 frozen", clk_cnt_o, c0);
    wr(2'd2, 32'h04);

    // R8 busy counting
    wr(2'd2, 32'h1C0);
    chk("R9 counters cleared", tmem_cnt_o, 0);
    tmem_busy_i = 1'b1;
    repeat (4) step();
    tmem_busy_i = 1'b0;
    pipe_busy_i = 1'b1;
    repeat (2) step();
    pipe_busy_i = 1'b0;
    step();
    chk("R8 tmem count", tmem_cnt_o, 4);
    chk("R8 pipe count", pipe_cnt_o, 2);
    chk("R8 cmd count", cmd_cnt_o, 0);
    chk("R8 busy bits", status_o[6:4], 3'b011);

    // R9 clear overrides increment
    tmem_busy_i = 1'b1;
    wr(2'd2, 32'h40);
    tmem_busy_i = 1'b0;
    chk("R9 tmem cleared", tmem_cnt_o, 0);
    chk("R9 tmem bit cleared", status_o[4], 0);
    chk("R9 pipe untouched", pipe_cnt_o, 2);

    // R10 clock clear only
    wr(2'd2, 32'h200);
    chk("R10 clock zeroed", clk_cnt_o, 0);
    chk("R10 pipe bit kept", status_o[5], 1);
    chk("R10 pipe count kept", pipe_cnt_o, 2);
    chk("R11 reserved zero", {status_o[9:7], status_o[3]}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule